// File: doc/BRIEF.md
# Ring Buffer Pointer Register Bank

This block keeps the programmable state of a command ring that lives in system memory: where the ring starts, its last slot, the producer and consumer positions, a stop position, two fill thresholds and a running count of bytes between producer and consumer. Software reaches every value through a 16-bit register port. Each 32-bit value is split into two halfwords that are written one at a time. A small control word, a write-only clear word, a token halfword and two sticky status flags sit on the same port.

A producer pushes data in 32-byte bursts. When linking is enabled, each burst pulse moves the producer pointer forward by one burst, or back to the ring start once it stands on the last slot, and adds one burst to the byte count. Memory fetching and interrupt generation belong to neighbouring blocks. This bank only drives its pointers, enables and flags out to them, and it takes the two threshold events in as set pulses.

Top module: `ring_ptr_bank`

## Requirements
- R1: After reset every register reads zero and every output is zero.
- R2: The halfword map is fixed. Index 0 is status, index 1 is control, index 2 is clear and index 3 is token. Each 32-bit register uses an even index for its low half and the next odd index for its high half: base 16/17, last slot 18/19, high mark 20/21, low mark 22/23, fill count 24/25, producer pointer 26/27, consumer pointer 28/29, stop pointer 30/31. The index is address bits [11:1]. A low-half write leaves bits [31:16] unchanged, and a high-half write leaves bits [15:0] unchanged.
- R3: Low-half writes to base, last slot, fill count, producer, consumer and stop pointers force bits [4:0] to zero. Low-half writes to the high and low marks are stored as written.
- R4: Reads are combinational in the same cycle. An index of 32 or more reads zero. Indices below 32 that are not mapped, and the clear word, also read zero.
- R5: With link enabled, a burst pulse loads the producer pointer from base when it equals the last slot. Otherwise it adds 32 to the producer pointer. The new value is visible after the next clock edge.
- R6: Each linked burst adds 32 to the fill count.
- R7: With link disabled, a burst pulse changes neither the producer pointer nor the fill count.
- R8: Writes to the status halfword change nothing. Status bit 0 is the overflow flag and bit 1 is the underflow flag.
- R9: The overflow and underflow flags are set by their input pulses and stay set. Writing the clear word with bit 0 set clears overflow, and with bit 1 set clears underflow. A set pulse in the same cycle as a clear keeps the flag set.
- R10: Control bits are [0] fetch enable, [1] stop enable, [2] overflow interrupt enable, [3] underflow interrupt enable, [4] link enable and [5] stop interrupt enable. Each drives its own output. Control bits [15:6] read as zero.
- R11: A bus write to the producer pointer or the fill count in the same cycle as a linked burst takes the written half and discards that register's burst update.
- R12: The token halfword stores all 16 written bits, reads them back and drives them out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address; bits [11:1] select the halfword |
| bus_we | input | 1 | Write strobe for one halfword |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| burst_i | input | 1 | One producer burst of 32 bytes |
| ovf_set_i | input | 1 | Sets the overflow flag |
| unf_set_i | input | 1 | Sets the underflow flag |
| ring_base_o | output | 32 | Ring start address |
| ring_last_o | output | 32 | Last slot address (inclusive) |
| wr_ptr_o | output | 32 | Producer pointer |
| rd_ptr_o | output | 32 | Consumer pointer |
| brk_ptr_o | output | 32 | Stop pointer |
| hi_mark_o | output | 32 | High fill threshold |
| lo_mark_o | output | 32 | Low fill threshold |
| fill_cnt_o | output | 32 | Producer-to-consumer byte count |
| fetch_en_o | output | 1 | Control bit 0 |
| stop_en_o | output | 1 | Control bit 1 |
| ovf_irq_en_o | output | 1 | Control bit 2 |
| unf_irq_en_o | output | 1 | Control bit 3 |
| link_en_o | output | 1 | Control bit 4 |
| stop_irq_en_o | output | 1 | Control bit 5 |
| token_o | output | 16 | Token halfword |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| unf_flag_o | output | 1 | Sticky underflow flag |

## Verification
Every register update, whether from a bus write, a burst or a set or clear of a flag, is due one clock edge after the stimulus. Read data is due in the same cycle as its address. The bench drives every input just after a falling edge and holds it for exactly one rising edge. It checks register contents at the following falling edge and samples read data 1 ns after it sets the address, so each check lands in the first cycle where its result is defined. Two cases put several stimuli in one cycle: a write combined with a burst, and a set combined with a clear. Both are applied in a single cycle and checked at the next falling edge.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

   localparam int HALF_W     = 16;
   localparam int NUM_HALF   = 32;
   localparam int NUM_WIDE   = 8;

   // halfword indices of the narrow registers
   localparam int IDX_STATUS = 0;
   localparam int IDX_CTRL   = 1;
   localparam int IDX_CLEAR  = 2;
   localparam int IDX_TOKEN  = 3;
   localparam int IDX_WIDE0  = 16;

   // slot order of the wide registers; slot w sits at IDX_WIDE0 + 2*w
   localparam int W_BASE = 0;
   localparam int W_LAST = 1;
   localparam int W_HIMK = 2;
   localparam int W_LOMK = 3;
   localparam int W_FILL = 4;
   localparam int W_WPTR = 5;
   localparam int W_RPTR = 6;
   localparam int W_BRK  = 7;

   localparam int CTRL_BITS = 6;

   typedef struct packed {
      logic stop_irq_en;   // [5]
      logic link_en;       // [4]
      logic unf_irq_en;    // [3]
      logic ovf_irq_en;    // [2]
      logic stop_en;       // [1]
      logic fetch_en;      // [0]
   } ctrl_t;

   function automatic bit slot_is_aligned(input int slot);
      return (slot != W_HIMK) && (slot != W_LOMK);
   endfunction

endpackage

// File: rtl/rpb_split_reg.sv
module rpb_split_reg #(
   parameter int  REG_W     = 32,
   parameter int  HALF_W    = 16,
   parameter int  ALIGN_LSB = 5,
   parameter bit  MASK_LOW  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_lo,
   input  logic              we_hi,
   input  logic [HALF_W-1:0] wdata,
   input  logic              upd_en,
   input  logic [REG_W-1:0]  upd_val,
   output logic [REG_W-1:0]  q
);

   if (REG_W != 2 * HALF_W) begin : g_bad_width
      $error("rpb_split_reg: REG_W must be twice HALF_W");
   end
   if (ALIGN_LSB < 1 || ALIGN_LSB >= HALF_W) begin : g_bad_align
      $error("rpb_split_reg: ALIGN_LSB out of range");
   end

   logic [HALF_W-1:0] lo_in;

   if (MASK_LOW) begin : g_masked
      assign lo_in = {wdata[HALF_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
   end else begin : g_plain
      assign lo_in = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we_lo || we_hi) begin
         if (we_lo) q[HALF_W-1:0]     <= lo_in;
         if (we_hi) q[REG_W-1:HALF_W] <= wdata;
      end else if (upd_en) begin
         q <= upd_val;
      end
   end

   // R2: a low-half write leaves the upper half alone
   a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (we_lo && !we_hi) |=> q[REG_W-1:HALF_W] == $past(q[REG_W-1:HALF_W]));

   // R2: a high-half write leaves the lower half alone
   a_r2_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (we_hi && !we_lo) |=> q[HALF_W-1:0] == $past(q[HALF_W-1:0]));

   if (MASK_LOW) begin : g_align_chk
      // R3: aligned registers never hold low address bits after a low write
      a_r3_low_aligned: assert property (@(posedge clk) disable iff (!rst_n)
         we_lo |=> q[ALIGN_LSB-1:0] == '0);
   end

endmodule

// File: rtl/rpb_ctrl_bank.sv
module rpb_ctrl_bank
   import rpb_pkg::*;
#(
   parameter int IDX_W  = 11,
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [HALF_W-1:0] wdata,
   input  logic              ovf_set,
   input  logic              unf_set,
   output ctrl_t             ctrl,
   output logic [HALF_W-1:0] token,
   output logic              ovf_flag,
   output logic              unf_flag
);

   if (HALF_W < CTRL_BITS) begin : g_bad_half
      $error("rpb_ctrl_bank: HALF_W too narrow for control bits");
   end

   logic wr_ctrl, wr_clear, wr_token, wr_status;
   assign wr_ctrl   = we && (idx == IDX_W'(IDX_CTRL));
   assign wr_clear  = we && (idx == IDX_W'(IDX_CLEAR));
   assign wr_token  = we && (idx == IDX_W'(IDX_TOKEN));
   assign wr_status = we && (idx == IDX_W'(IDX_STATUS));

   logic clr_ovf, clr_unf;
   assign clr_ovf = wr_clear && wdata[0];
   assign clr_unf = wr_clear && wdata[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl     <= '0;
         token    <= '0;
         ovf_flag <= 1'b0;
         unf_flag <= 1'b0;
      end else begin
         if (wr_ctrl)  ctrl  <= ctrl_t'(wdata[CTRL_BITS-1:0]);
         if (wr_token) token <= wdata;
         ovf_flag <= (ovf_flag && !clr_ovf) || ovf_set;
         unf_flag <= (unf_flag && !clr_unf) || unf_set;
      end
   end

   // R8: status writes touch neither flag
   a_r8_status_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && !ovf_set && !unf_set) |=> $stable(ovf_flag) && $stable(unf_flag));

   // R9: clear bit 0 drops overflow unless a set arrives with it
   a_r9_clear_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clear && wdata[0] && !ovf_set) |=> !ovf_flag);

   // R9: clear bit 1 drops underflow unless a set arrives with it
   a_r9_clear_unf: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clear && wdata[1] && !unf_set) |=> !unf_flag);

   // R9: a set pulse always wins
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set |=> ovf_flag);

   // R12: token holds when not written
   a_r12_token_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_token |=> $stable(token));

endmodule

// File: rtl/rpb_read_mux.sv
module rpb_read_mux #(
   parameter int IDX_W    = 11,
   parameter int HALF_W   = 16,
   parameter int NUM_HALF = 32
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [HALF_W-1:0] halves [NUM_HALF],
   output logic [HALF_W-1:0] rdata
);

   localparam int SEL_W = $clog2(NUM_HALF);

   if ((1 << SEL_W) != NUM_HALF || SEL_W > IDX_W) begin : g_bad_map
      $error("rpb_read_mux: NUM_HALF must be a power of two within the index range");
   end

   logic in_range;
   assign in_range = (idx < IDX_W'(NUM_HALF));

   always_comb begin
      rdata = '0;
      if (in_range) rdata = halves[idx[SEL_W-1:0]];
   end

endmodule

// File: rtl/ring_ptr_bank.sv
module ring_ptr_bank
   import rpb_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int REG_W       = 32,
   parameter int BURST_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   input  logic              burst_i,
   input  logic              ovf_set_i,
   input  logic              unf_set_i,
   output logic [REG_W-1:0]  ring_base_o,
   output logic [REG_W-1:0]  ring_last_o,
   output logic [REG_W-1:0]  wr_ptr_o,
   output logic [REG_W-1:0]  rd_ptr_o,
   output logic [REG_W-1:0]  brk_ptr_o,
   output logic [REG_W-1:0]  hi_mark_o,
   output logic [REG_W-1:0]  lo_mark_o,
   output logic [REG_W-1:0]  fill_cnt_o,
   output logic              fetch_en_o,
   output logic              stop_en_o,
   output logic              ovf_irq_en_o,
   output logic              unf_irq_en_o,
   output logic              link_en_o,
   output logic              stop_irq_en_o,
   output logic [15:0]       token_o,
   output logic              ovf_flag_o,
   output logic              unf_flag_o
);

   localparam int IDX_W     = ADDR_W - 1;
   localparam int ALIGN_LSB = $clog2(BURST_BYTES);

   if (REG_W != 2 * HALF_W) begin : g_bad_reg
      $error("ring_ptr_bank: REG_W must be two halfwords");
   end
   if ((1 << ALIGN_LSB) != BURST_BYTES) begin : g_bad_burst
      $error("ring_ptr_bank: BURST_BYTES must be a power of two");
   end
   if (IDX_W < $clog2(NUM_HALF)) begin : g_bad_addr
      $error("ring_ptr_bank: ADDR_W too small for the register map");
   end

   logic [IDX_W-1:0] idx;
   logic             unused_addr_lsb;
   assign idx             = bus_addr[ADDR_W-1:1];
   assign unused_addr_lsb = bus_addr[0];

   // ---------------- control, token and flags ----------------
   ctrl_t             ctrl;
   logic [HALF_W-1:0] token;
   logic              ovf_flag, unf_flag;

   rpb_ctrl_bank #(.IDX_W(IDX_W), .HALF_W(HALF_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bus_we),
      .idx      (idx),
      .wdata    (bus_wdata),
      .ovf_set  (ovf_set_i),
      .unf_set  (unf_set_i),
      .ctrl     (ctrl),
      .token    (token),
      .ovf_flag (ovf_flag),
      .unf_flag (unf_flag)
   );

   // ---------------- wide pointer registers ----------------
   logic [REG_W-1:0] wide_q   [NUM_WIDE];
   logic [REG_W-1:0] upd_val  [NUM_WIDE];
   logic             upd_en   [NUM_WIDE];
   logic             wr_lo    [NUM_WIDE];
   logic             wr_hi    [NUM_WIDE];

   logic             burst_go;
   logic [REG_W-1:0] wptr_next;

   assign burst_go  = burst_i && ctrl.link_en;
   assign wptr_next = (wide_q[W_WPTR] == wide_q[W_LAST]) ? wide_q[W_BASE]
                    : wide_q[W_WPTR] + REG_W'(BURST_BYTES);

   for (genvar w = 0; w < NUM_WIDE; w++) begin : g_wide
      assign wr_lo[w] = bus_we && (idx == IDX_W'(IDX_WIDE0 + 2 * w));
      assign wr_hi[w] = bus_we && (idx == IDX_W'(IDX_WIDE0 + 2 * w + 1));

      if (w == W_WPTR) begin : g_upd_wptr
         assign upd_en[w]  = burst_go;
         assign upd_val[w] = wptr_next;
      end else if (w == W_FILL) begin : g_upd_fill
         assign upd_en[w]  = burst_go;
         assign upd_val[w] = wide_q[w] + REG_W'(BURST_BYTES);
      end else begin : g_upd_none
         assign upd_en[w]  = 1'b0;
         assign upd_val[w] = '0;
      end

      rpb_split_reg #(
         .REG_W     (REG_W),
         .HALF_W    (HALF_W),
         .ALIGN_LSB (ALIGN_LSB),
         .MASK_LOW  (slot_is_aligned(w))
      ) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_lo   (wr_lo[w]),
         .we_hi   (wr_hi[w]),
         .wdata   (bus_wdata),
         .upd_en  (upd_en[w]),
         .upd_val (upd_val[w]),
         .q       (wide_q[w])
      );
   end

   // ---------------- read path ----------------
   logic [HALF_W-1:0] halves [NUM_HALF];

   always_comb begin
      for (int h = 0; h < NUM_HALF; h++) halves[h] = '0;
      halves[IDX_STATUS] = {{(HALF_W-2){1'b0}}, unf_flag, ovf_flag};
      halves[IDX_CTRL]   = {{(HALF_W-CTRL_BITS){1'b0}}, ctrl};
      halves[IDX_TOKEN]  = token;
      for (int w = 0; w < NUM_WIDE; w++) begin
         halves[IDX_WIDE0 + 2 * w]     = wide_q[w][HALF_W-1:0];
         halves[IDX_WIDE0 + 2 * w + 1] = wide_q[w][REG_W-1:HALF_W];
      end
   end

   rpb_read_mux #(.IDX_W(IDX_W), .HALF_W(HALF_W), .NUM_HALF(NUM_HALF)) u_rmux (
      .idx    (idx),
      .halves (halves),
      .rdata  (bus_rdata)
   );

   // ---------------- outputs ----------------
   assign ring_base_o   = wide_q[W_BASE];
   assign ring_last_o   = wide_q[W_LAST];
   assign wr_ptr_o      = wide_q[W_WPTR];
   assign rd_ptr_o      = wide_q[W_RPTR];
   assign brk_ptr_o     = wide_q[W_BRK];
   assign hi_mark_o     = wide_q[W_HIMK];
   assign lo_mark_o     = wide_q[W_LOMK];
   assign fill_cnt_o    = wide_q[W_FILL];
   assign fetch_en_o    = ctrl.fetch_en;
   assign stop_en_o     = ctrl.stop_en;
   assign ovf_irq_en_o  = ctrl.ovf_irq_en;
   assign unf_irq_en_o  = ctrl.unf_irq_en;
   assign link_en_o     = ctrl.link_en;
   assign stop_irq_en_o = ctrl.stop_irq_en;
   assign token_o       = token;
   assign ovf_flag_o    = ovf_flag;
   assign unf_flag_o    = unf_flag;

   // ---------------- assertions ----------------
   logic wr_wptr_any, wr_fill_any;
   assign wr_wptr_any = wr_lo[W_WPTR] || wr_hi[W_WPTR];
   assign wr_fill_any = wr_lo[W_FILL] || wr_hi[W_FILL];

   // R4: indices at or past the map end read zero
   a_r4_high_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (idx >= IDX_W'(NUM_HALF)) |-> bus_rdata == '0);

   // R5: producer pointer reloads from base on the last slot
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_go && !wr_wptr_any && wr_ptr_o == ring_last_o) |=> wr_ptr_o == $past(ring_base_o));

   // R5: producer pointer steps one burst elsewhere
   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_go && !wr_wptr_any && wr_ptr_o != ring_last_o)
         |=> wr_ptr_o == $past(wr_ptr_o) + REG_W'(BURST_BYTES));

   // R6: fill count grows by one burst
   a_r6_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_go && !wr_fill_any) |=> fill_cnt_o == $past(fill_cnt_o) + REG_W'(BURST_BYTES));

   // R7: unlinked bursts are inert
   a_r7_no_link: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_i && !link_en_o && !bus_we) |=> $stable(wr_ptr_o) && $stable(fill_cnt_o));

   // R11: a low-half write to the producer pointer beats a burst
   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_go && wr_lo[W_WPTR]) |=> wr_ptr_o[REG_W-1:HALF_W] == $past(wr_ptr_o[REG_W-1:HALF_W]));

endmodule

// File: tb/sim_ring_ptr_bank.sv
module sim_ring_ptr_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        burst_i = 1'b0, ovf_set_i = 1'b0, unf_set_i = 1'b0;
   logic [31:0] ring_base_o, ring_last_o, wr_ptr_o, rd_ptr_o, brk_ptr_o;
   logic [31:0] hi_mark_o, lo_mark_o, fill_cnt_o;
   logic        fetch_en_o, stop_en_o, ovf_irq_en_o, unf_irq_en_o, link_en_o, stop_irq_en_o;
   logic [15:0] token_o;
   logic        ovf_flag_o, unf_flag_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ring_ptr_bank u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .burst_i(burst_i),
      .ovf_set_i(ovf_set_i), .unf_set_i(unf_set_i),
      .ring_base_o(ring_base_o), .ring_last_o(ring_last_o), .wr_ptr_o(wr_ptr_o),
      .rd_ptr_o(rd_ptr_o), .brk_ptr_o(brk_ptr_o), .hi_mark_o(hi_mark_o),
      .lo_mark_o(lo_mark_o), .fill_cnt_o(fill_cnt_o), .fetch_en_o(fetch_en_o),
      .stop_en_o(stop_en_o), .ovf_irq_en_o(ovf_irq_en_o), .unf_irq_en_o(unf_irq_en_o),
      .link_en_o(link_en_o), .stop_irq_en_o(stop_irq_en_o), .token_o(token_o),
      .ovf_flag_o(ovf_flag_o), .unf_flag_o(unf_flag_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [15:0] d);
      @(negedge clk);
      bus_addr = 12'(idx << 1); bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [15:0] v);
      @(negedge clk);
      bus_addr = 12'(idx << 1);
      #1 v = bus_rdata;
   endtask

   task automatic burst();
      @(negedge clk); burst_i = 1'b1;
      @(negedge clk); burst_i = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      logic [15:0] acc = '0;
      for (int i = 0; i < 32; i++) begin
         rd(i, v);
         acc |= v;
      end
      chk("R1 all halfwords zero", 32'(acc), 32'h0);
      chk("R1 pointers zero", wr_ptr_o | ring_base_o | fill_cnt_o | hi_mark_o, 32'h0);
      chk("R1 flags/ctrl zero", {ovf_flag_o, unf_flag_o, link_en_o, fetch_en_o, token_o}, 32'h0);
   endtask

   task automatic t_halves();
      logic [15:0] v;
      wr(29, 16'h1234);
      wr(28, 16'hABCD);
      chk("R2 rd ptr lo keeps hi", rd_ptr_o, 32'h1234ABC0);
      wr(29, 16'h5678);
      chk("R2 rd ptr hi keeps lo", rd_ptr_o, 32'h5678ABC0);
      rd(29, v);
      chk("R2 readback hi half", 32'(v), 32'h5678);
      rd(28, v);
      chk("R3 readback masked lo", 32'(v), 32'hABC0);
   endtask

   task automatic t_masks();
      wr(20, 16'hFFFF);
      chk("R3 high mark unmasked", hi_mark_o, 32'h0000FFFF);
      wr(22, 16'h001F);
      chk("R3 low mark unmasked", lo_mark_o, 32'h0000001F);
      wr(30, 16'h003F);
      chk("R3 stop ptr masked", brk_ptr_o, 32'h00000020);
      wr(16, 16'h101F);
      chk("R3 base masked", ring_base_o, 32'h00001000);
      wr(24, 16'hFFFF);
      chk("R3 fill masked", fill_cnt_o, 32'h0000FFE0);
      wr(24, 16'h0000);
   endtask

   task automatic t_read_range();
      logic [15:0] v;
      rd(32, v);
      chk("R4 index 32 reads zero", 32'(v), 32'h0);
      rd(2047, v);
      chk("R4 top index reads zero", 32'(v), 32'h0);
      rd(5, v);
      chk("R4 unmapped low index zero", 32'(v), 32'h0);
      wr(2, 16'hFFFC);
      rd(2, v);
      chk("R4 clear word reads zero", 32'(v), 32'h0);
   endtask

   task automatic t_ctrl();
      logic [15:0] v;
      wr(1, 16'hFFFF);
      chk("R10 all enables", {26'h0, stop_irq_en_o, link_en_o, unf_irq_en_o,
                              ovf_irq_en_o, stop_en_o, fetch_en_o}, 32'h3F);
      rd(1, v);
      chk("R10 ctrl upper bits read zero", 32'(v), 32'h003F);
      wr(1, 16'h0004);
      chk("R10 bit2 is ovf irq", {26'h0, stop_irq_en_o, link_en_o, unf_irq_en_o,
                                  ovf_irq_en_o, stop_en_o, fetch_en_o}, 32'h04);
      wr(1, 16'h0010);
      chk("R10 bit4 is link", {31'h0, link_en_o}, 32'h1);
      chk("R10 only link set", {26'h0, stop_irq_en_o, 1'b0, unf_irq_en_o,
                                ovf_irq_en_o, stop_en_o, fetch_en_o}, 32'h0);
   endtask

   task automatic t_burst();
      wr(16, 16'h1000); wr(17, 16'h0000);
      wr(18, 16'h1040); wr(19, 16'h0000);
      wr(26, 16'h1020); wr(27, 16'h0000);
      wr(24, 16'h0000);
      wr(1, 16'h0010);
      burst();
      chk("R5 step by 32", wr_ptr_o, 32'h00001040);
      chk("R6 fill +32", fill_cnt_o, 32'd32);
      burst();
      chk("R5 wrap to base at last slot", wr_ptr_o, 32'h00001000);
      chk("R6 fill +64", fill_cnt_o, 32'd64);
      burst();
      chk("R5 step after wrap", wr_ptr_o, 32'h00001020);
      chk("R6 fill +96", fill_cnt_o, 32'd96);
   endtask

   task automatic t_no_link();
      wr(1, 16'h002F);
      burst();
      chk("R7 unlinked burst ptr", wr_ptr_o, 32'h00001020);
      chk("R7 unlinked burst fill", fill_cnt_o, 32'd96);
   endtask

   task automatic t_write_wins();
      wr(1, 16'h0010);
      @(negedge clk);
      bus_addr = 12'(26 << 1); bus_we = 1'b1; bus_wdata = 16'h2004; burst_i = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; burst_i = 1'b0;
      chk("R11 write beats burst on ptr", wr_ptr_o, 32'h00002000);
      chk("R6 fill still grows", fill_cnt_o, 32'd128);
      @(negedge clk);
      bus_addr = 12'(25 << 1); bus_we = 1'b1; bus_wdata = 16'h0001; burst_i = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; burst_i = 1'b0;
      chk("R11 write beats burst on fill", fill_cnt_o, 32'h00010080);
      chk("R5 ptr steps while fill written", wr_ptr_o, 32'h00002020);
   endtask

   task automatic t_flags();
      logic [15:0] v;
      @(negedge clk); ovf_set_i = 1'b1; unf_set_i = 1'b1;
      @(negedge clk); ovf_set_i = 1'b0; unf_set_i = 1'b0;
      rd(0, v);
      chk("R9 both flags set", 32'(v), 32'h3);
      wr(0, 16'h0000);
      rd(0, v);
      chk("R8 status write ignored", 32'(v), 32'h3);
      wr(2, 16'h0001);
      chk("R9 clear overflow only", {30'h0, unf_flag_o, ovf_flag_o}, 32'h2);
      wr(2, 16'h0002);
      chk("R9 clear underflow", {30'h0, unf_flag_o, ovf_flag_o}, 32'h0);
      @(negedge clk);
      bus_addr = 12'(2 << 1); bus_we = 1'b1; bus_wdata = 16'h0003; ovf_set_i = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; ovf_set_i = 1'b0;
      chk("R9 set beats clear", {30'h0, unf_flag_o, ovf_flag_o}, 32'h1);
   endtask

   task automatic t_token();
      logic [15:0] v;
      wr(3, 16'hBEEF);
      chk("R12 token out", 32'(token_o), 32'hBEEF);
      rd(3, v);
      chk("R12 token readback", 32'(v), 32'hBEEF);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_halves();
      t_masks();
      t_read_range();
      t_ctrl();
      t_burst();
      t_no_link();
      t_write_wins();
      t_flags();
      t_token();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule